// File: doc/BRIEF.md
# Two-Caller Shared Procedure Call Element

This block lets two clients share one procedure, for example a shared increment unit, using two-phase (transition) handshakes. Each client signals a call by toggling its own request line. The block merges the two request streams into one outgoing request, which toggles whenever either client's request toggles. When the shared procedure answers by toggling its acknowledge, the block steers that answer back as a toggle on the done line of the client that made the call, and of no other client.

Every line carries meaning in its changes, not in its level, so rising and falling edges are handled alike. Each done line is a Muller C-element half. Its inputs are the client's own request and a phase term formed from the shared acknowledge XOR the other client's done line. The done line holds its value until both inputs agree, and then takes their common value. The halves are registers on the system clock, so a done toggle appears on the first rising clock edge after the acknowledge toggle. The clients must take turns: a second call may start only after the first has completed. A sticky flag reports a call overlap, or an acknowledge with no call outstanding.

Top module: `call_merge2`

## Requirements
- R1: While reset is asserted and after it is released, with all inputs low, procReq, doneA, doneB and protoErr are all low.
- R2: procReq always equals callReqA XOR callReqB in the same cycle, so a toggle on either request input toggles procReq.
- R3: While client A has a call outstanding (callReqA differs from doneA), a toggle of procAck that makes procAck XOR doneB equal to callReqA makes doneA take the value of callReqA on the next rising clock edge.
- R4: Symmetrically, while client B has a call outstanding, a toggle of procAck that makes procAck XOR doneA equal to callReqB makes doneB take the value of callReqB on the next rising clock edge.
- R5: A done output does not change while its client's call is outstanding and procAck has not toggled.
- R6: An acknowledge that completes one client's call leaves the other client's done output unchanged, and the two done outputs never change in the same cycle.
- R7: If both clients have outstanding calls at once, protoErr goes high on the next rising clock edge.
- R8: If procAck toggles while no call is outstanding, protoErr goes high on the next rising clock edge. protoErr then stays high until reset, and the done outputs stay unchanged.
- R9: Calls made with falling request edges complete in the same way as calls made with rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| callReqA | input | 1 | Client A call request (transition) |
| callReqB | input | 1 | Client B call request (transition) |
| procAck | input | 1 | Acknowledge from the shared procedure (transition) |
| procReq | output | 1 | Merged request to the shared procedure (transition) |
| doneA | output | 1 | Completion toggle to client A |
| doneB | output | 1 | Completion toggle to client B |
| protoErr | output | 1 | Sticky protocol-violation flag |

## Verification
The assertions assume that the inputs change only between clock edges. They also assume that procAck is held low during reset, so that the acknowledge value seen on the previous cycle matches the value the block keeps after reset. The stimulus changes every input half a cycle away from the rising edge. It keeps procAck low around both resets, and it raises an overlap or a stray acknowledge only in the segments that deliberately test the error flag.

// File: rtl/call_pkg.sv
package call_pkg;
  localparam int CALLERS = 2;
  localparam int IDX_W   = (CALLERS > 1) ? $clog2(CALLERS) : 1;

  typedef struct packed {
    logic [CALLERS-1:0] load;
    logic               raiseErr;
  } callStrobe_t;
endpackage

// File: rtl/call_ctrl.sv
module call_ctrl
  import call_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [CALLERS-1:0] callReq,
  input  logic               procAck,
  input  logic [CALLERS-1:0] done,
  output callStrobe_t        strobe
);
  logic               ackPrev;
  logic [CALLERS-1:0] pend;
  logic [CALLERS-1:0] xPhase;
  logic [CALLERS-1:0] loadVec;
  logic               ackToggle;

  always_ff @(posedge clk) begin
    if (!rstN) ackPrev <= 1'b0;
    else       ackPrev <= procAck;
  end

  assign pend      = callReq ^ done;
  assign ackToggle = procAck ^ ackPrev;

  for (genvar i = 0; i < CALLERS; i++) begin : g_half
    // the phase term of each half combines the shared acknowledge with the partner's done
    assign xPhase[i]  = procAck ^ done[CALLERS-1-i];
    assign loadVec[i] = (callReq[i] == xPhase[i]) && (done[i] != callReq[i]);
  end

  always_comb begin
    strobe.load     = loadVec;
    strobe.raiseErr = (&pend) | (ackToggle & ~(|pend));
  end
endmodule

// File: rtl/call_path.sv
module call_path
  import call_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [CALLERS-1:0] callReq,
  input  callStrobe_t        strobe,
  output logic [CALLERS-1:0] done,
  output logic               procReq,
  output logic               protoErr
);
  for (genvar i = 0; i < CALLERS; i++) begin : g_done
    always_ff @(posedge clk) begin
      if (!rstN)               done[i] <= 1'b0;
      else if (strobe.load[i]) done[i] <= callReq[i];
    end
  end

  assign procReq = ^callReq;

  always_ff @(posedge clk) begin
    if (!rstN)                protoErr <= 1'b0;
    else if (strobe.raiseErr) protoErr <= 1'b1;
  end
endmodule

// File: rtl/call_merge2.sv
module call_merge2
  import call_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic callReqA,
  input  logic callReqB,
  input  logic procAck,
  output logic procReq,
  output logic doneA,
  output logic doneB,
  output logic protoErr
);
  logic [CALLERS-1:0] reqVec;
  logic [CALLERS-1:0] doneVec;
  callStrobe_t        strobe;

  assign reqVec = {callReqB, callReqA};
  assign doneA  = doneVec[0];
  assign doneB  = doneVec[1];

  call_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .callReq(reqVec), .procAck(procAck),
    .done(doneVec), .strobe(strobe)
  );

  call_path u_path (
    .clk(clk), .rstN(rstN), .callReq(reqVec), .strobe(strobe),
    .done(doneVec), .procReq(procReq), .protoErr(protoErr)
  );
endmodule

// File: rtl/call_merge2_chk.sv
module call_merge2_chk (
  input logic clk,
  input logic rstN,
  input logic callReqA,
  input logic callReqB,
  input logic procAck,
  input logic procReq,
  input logic doneA,
  input logic doneB,
  input logic protoErr
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (!doneA && !doneB && !protoErr));

  // R2
  req_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((callReqA != $past(callReqA)) ^ (callReqB != $past(callReqB))) |-> (procReq != $past(procReq)));

  // R3
  done_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((callReqA != doneA) && ((procAck ^ doneB) == callReqA)) |=> (doneA == $past(callReqA)));

  // R4
  done_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((callReqB != doneB) && ((procAck ^ doneA) == callReqB)) |=> (doneB == $past(callReqB)));

  // R5
  hold_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneA != $past(doneA)) |-> ($past(callReqA) != $past(doneA)));

  // R6
  one_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !((doneA != $past(doneA)) && (doneB != $past(doneB))));

  // R7
  overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((callReqA != doneA) && (callReqB != doneB)) |=> protoErr);

  // R8
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(protoErr) |-> protoErr);
endmodule

bind call_merge2 call_merge2_chk u_chk (
  .clk(clk), .rstN(rstN), .callReqA(callReqA), .callReqB(callReqB),
  .procAck(procAck), .procReq(procReq), .doneA(doneA), .doneB(doneB),
  .protoErr(protoErr)
);

// File: tb/test_call_merge2.sv
module test_call_merge2;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic callReqA = 1'b0, callReqB = 1'b0, procAck = 1'b0;
  logic procReq, doneA, doneB, protoErr;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  expReq;
    logic  expA;
    logic  expB;
    logic  expErr;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  bit       done = 1'b0;

  always #5 clk = ~clk;

  call_merge2 i_call_merge2 (
    .clk(clk), .rstN(rstN), .callReqA(callReqA), .callReqB(callReqB),
    .procAck(procAck), .procReq(procReq), .doneA(doneA), .doneB(doneB),
    .protoErr(protoErr)
  );

  task automatic cmp(input logic act, input logic exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // driver: apply inputs on the falling edge and queue the result expected after the next rising edge
  task automatic step(input logic a, input logic b, input logic k,
                      input logic eA, input logic eB, input logic eE, input string tag);
    expItem_t it;
    @(negedge clk);
    callReqA = a; callReqB = b; procAck = k;
    it.expReq = a ^ b; it.expA = eA; it.expB = eB; it.expErr = eE; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; callReqA = 1'b0; callReqB = 1'b0; procAck = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    cmp(procReq, 1'b0, "procReq", "R1");
    cmp(doneA, 1'b0, "doneA", "R1");
    cmp(doneB, 1'b0, "doneB", "R1");
    cmp(protoErr, 1'b0, "protoErr", "R1");
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        cmp(procReq, it.expReq, "procReq", it.tag);
        cmp(doneA, it.expA, "doneA", it.tag);
        cmp(doneB, it.expB, "doneB", it.tag);
        cmp(protoErr, it.expErr, "protoErr", it.tag);
      end
    end
  end

  initial begin
    doReset();
    step(1, 0, 0, 0, 0, 0, "R2 R5 call A");
    step(1, 0, 0, 0, 0, 0, "R5 A waits");
    step(1, 0, 1, 1, 0, 0, "R3 ack to A");
    step(1, 1, 1, 1, 0, 0, "R2 call B");
    step(1, 1, 0, 1, 1, 0, "R4 R6 ack to B");
    step(0, 1, 0, 1, 1, 0, "R9 falling call A");
    step(0, 1, 1, 0, 1, 0, "R9 R3 ack A falling");
    step(0, 0, 1, 0, 1, 0, "R9 falling call B");
    step(0, 0, 0, 0, 0, 0, "R9 R4 ack B falling");
    step(0, 0, 1, 0, 0, 1, "R8 stray ack");
    step(0, 0, 1, 0, 0, 1, "R8 sticky");
    step(0, 0, 1, 0, 0, 1, "R8 done unchanged");
    @(negedge clk);
    procAck = 1'b0;
    doReset();
    step(1, 0, 0, 0, 0, 0, "R7 first call");
    step(1, 1, 0, 0, 0, 1, "R7 overlap");
    step(1, 1, 0, 0, 0, 1, "R7 sticky");
    repeat (2) @(posedge clk);
    #3;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule